// File: doc/BRIEF.md
# Load-Use Stall Cycle Accountant

This block keeps cycle statistics for a simple in-order pipeline that issues either one instruction or a parallel pair of two. Each instruction is presented for a single clock with `ins_valid` high. It carries up to two source register numbers, an optional load destination register, branch information, markers for the first and last slot of its issue group, and a base cycle count. A lone instruction raises both `ins_first` and `ins_last`.

The accountant charges a load-use penalty each time a source register hits the set of registers loaded by the previous completed instruction. It charges a penalty for every taken branch. It reports the registered cycle total of each instruction. It also keeps five saturating running counters: total cycles, load-stall cycles, branch-stall cycles, taken branches and untaken branches. A parallel pair is charged the larger of its two instruction totals.

Top module: `lsa_cycle_acct`

## Requirements
- R1: While `rst` is high, and after it falls, `insn_cyc`, all five counters and both register masks are zero.
- R2: A valid instruction with `ld_en` high sets bit `ld_reg` (register numbers 0 to NREG-1) in the pending mask. At completion the pending mask becomes the active load mask that later instructions are checked against.
- R3: Each source whose enable is high and whose register bit is set in the active mask adds 2 load-stall cycles. Two enabled sources naming the same hit register add 4. A source whose enable is low adds nothing.
- R4: With `br_en`=1, `br_taken`=1 adds 2 branch-stall cycles and increments `taken_cnt`, and `br_taken`=0 increments `untaken_cnt`. With `br_en`=0 neither count moves, no branch stall is charged and `br_taken` is ignored.
- R5: One clock after a valid instruction, `insn_cyc` equals its base cycles plus the load and branch stall accumulated so far in its issue group, including stalls of the first slot of a pair.
- R6: An instruction with `ins_first`=1 clears the group stall accumulators, the pending mask and the running maximum before adding its own contribution. A lone instruction with no load therefore leaves the active mask empty.
- R7: At an instruction with `ins_last`=1, `total_cyc` grows by the larger of that instruction's total and the total recorded for the non-last slot of the group. A lone instruction adds its own total.
- R8: At an instruction with `ins_last`=1, `ld_stall_cyc` and `br_stall_cyc` grow by the group's accumulated load and branch stall. A stall is counted once per group.
- R9: Every counter saturates at its all-ones value and holds there.
- R10: While `ins_valid` is low, no output, counter or mask changes, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Instruction completes this cycle |
| ins_first | input | 1 | First slot of the issue group |
| ins_last | input | 1 | Last slot of the issue group |
| rd_a_en | input | 1 | Source A is read |
| rd_a_reg | input | IDX_W | Source A register number |
| rd_b_en | input | 1 | Source B is read |
| rd_b_reg | input | IDX_W | Source B register number |
| ld_en | input | 1 | Instruction is a load |
| ld_reg | input | IDX_W | Load destination register |
| br_en | input | 1 | Instruction is a branch |
| br_taken | input | 1 | Branch was taken |
| base_cyc | input | CYC_W | Base cycle cost |
| insn_cyc | output | CYC_W+2 | Cycle total of the last instruction |
| total_cyc | output | CNT_W | Accumulated total cycles |
| ld_stall_cyc | output | CNT_W | Accumulated load-stall cycles |
| br_stall_cyc | output | CNT_W | Accumulated branch-stall cycles |
| taken_cnt | output | CNT_W | Taken branch count |
| untaken_cnt | output | CNT_W | Untaken branch count |

## Verification
The assertions assume that issue groups are well formed: every group opens with `ins_first` and closes with `ins_last`, and it holds no more than two instructions. They also assume that every input is driven to a known level whenever `ins_valid` is high. The bench drives only lone instructions and complete two-slot pairs. Between instructions it parks the inputs at zero, or deliberately drives a load with `ins_valid` low to show that the masks are not touched. Saturation is reached by building the block with a narrow counter width, so the counters hit their ceiling within a few dozen instructions.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  localparam int LD_PEN  = 2;
  localparam int BR_PEN  = 2;
  localparam int NUM_CNT = 5;

  typedef enum int {
    CNT_TOTAL   = 0,
    CNT_LDSTALL = 1,
    CNT_BRSTALL = 2,
    CNT_TAKEN   = 3,
    CNT_UNTAKEN = 4
  } cnt_sel_e;
endpackage

// File: rtl/lsa_hazard.sv
module lsa_hazard #(
  parameter int NREG  = 16,
  parameter int NSRC  = 2,
  parameter int ACC_W = 8,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  valid,
  input  logic                  first,
  input  logic [NSRC-1:0]       src_en,
  input  logic [NSRC*IDX_W-1:0] src_idx,
  input  logic                  ld_en,
  input  logic [IDX_W-1:0]      ld_idx,
  output logic [ACC_W-1:0]      stall
);
  import lsa_pkg::*;

  logic [NREG-1:0] pend_q, active_q, pend_nxt, ld_bit;
  logic [NSRC-1:0] hit;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign hit[g] = src_en[g] & active_q[src_idx[g*IDX_W +: IDX_W]];
  end

  always_comb begin
    ld_bit = '0;
    if (ld_en) ld_bit[ld_idx] = 1'b1;
    pend_nxt = (first ? '0 : pend_q) | ld_bit;
  end

  always_comb begin
    stall = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (hit[i]) stall = stall + ACC_W'(LD_PEN);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= '0;
      active_q <= '0;
    end else if (valid) begin
      pend_q   <= pend_nxt;
      active_q <= pend_nxt;
    end
  end

  // R10: the active mask is frozen between instructions
  a_r10_mask_hold: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(active_q));

  // R3: no more penalty than one hit per source
  a_r3_hit_bound: assert property (@(posedge clk) disable iff (rst)
    valid |-> (int'(stall) <= NSRC * LD_PEN));

  // R2: a completed load leaves its bit in the active mask
  a_r2_load_visible: assert property (@(posedge clk) disable iff (rst)
    (valid && ld_en) |=> (active_q[$past(ld_idx)] == 1'b1));
endmodule

// File: rtl/lsa_pair.sv
module lsa_pair #(
  parameter int CYC_W = 8,
  parameter int ACC_W = 8,
  localparam int TOT_W = CYC_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic             first,
  input  logic             last,
  input  logic [CYC_W-1:0] base,
  input  logic [ACC_W-1:0] ld_inst,
  input  logic [ACC_W-1:0] br_inst,
  output logic [ACC_W-1:0] grp_ld,
  output logic [ACC_W-1:0] grp_br,
  output logic [TOT_W-1:0] insn_tot,
  output logic [TOT_W-1:0] charge
);
  logic [ACC_W-1:0] acc_ld_q, acc_br_q;
  logic [TOT_W-1:0] max_q, max_b;
  logic [ACC_W:0]   sum_ld, sum_br;

  always_comb begin
    sum_ld = {1'b0, (first ? '0 : acc_ld_q)} + {1'b0, ld_inst};
    sum_br = {1'b0, (first ? '0 : acc_br_q)} + {1'b0, br_inst};
    grp_ld = sum_ld[ACC_W] ? '1 : sum_ld[ACC_W-1:0];
    grp_br = sum_br[ACC_W] ? '1 : sum_br[ACC_W-1:0];
    insn_tot = TOT_W'(base) + TOT_W'(grp_ld) + TOT_W'(grp_br);
    max_b  = first ? '0 : max_q;
    charge = (max_b > insn_tot) ? max_b : insn_tot;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_ld_q <= '0;
      acc_br_q <= '0;
      max_q    <= '0;
    end else if (valid) begin
      acc_ld_q <= grp_ld;
      acc_br_q <= grp_br;
      if (!last) max_q <= insn_tot;
    end
  end

  // R7: the group charge never falls below the closing instruction's total
  a_r7_charge_floor: assert property (@(posedge clk) disable iff (rst)
    (valid && last) |-> (charge >= insn_tot));

  // R5: group accumulators only grow inside a group
  a_r5_acc_grow: assert property (@(posedge clk) disable iff (rst)
    (valid && !first) |-> (grp_ld >= acc_ld_q && grp_br >= acc_br_q));
endmodule

// File: rtl/lsa_sat_cnt.sv
module lsa_sat_cnt #(
  parameter int W     = 32,
  parameter int INC_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [INC_W-1:0] inc,
  output logic [W-1:0]     q
);
  logic [W:0] sum;

  always_comb sum = {1'b0, q} + (W+1)'(inc);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= sum[W] ? '1 : sum[W-1:0];
  end

  // R9: a saturated counter stays saturated
  a_r9_sat_hold: assert property (@(posedge clk) disable iff (rst)
    (q == '1) |=> (q == '1));

  // R10: no change without an enable
  a_r10_cnt_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q));
endmodule

// File: rtl/lsa_cycle_acct.sv
module lsa_cycle_acct #(
  parameter int NREG  = 16,
  parameter int CYC_W = 8,
  parameter int CNT_W = 32,
  localparam int IDX_W = $clog2(NREG),
  localparam int TOT_W = CYC_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ins_valid,
  input  logic             ins_first,
  input  logic             ins_last,
  input  logic             rd_a_en,
  input  logic [IDX_W-1:0] rd_a_reg,
  input  logic             rd_b_en,
  input  logic [IDX_W-1:0] rd_b_reg,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_reg,
  input  logic             br_en,
  input  logic             br_taken,
  input  logic [CYC_W-1:0] base_cyc,
  output logic [TOT_W-1:0] insn_cyc,
  output logic [CNT_W-1:0] total_cyc,
  output logic [CNT_W-1:0] ld_stall_cyc,
  output logic [CNT_W-1:0] br_stall_cyc,
  output logic [CNT_W-1:0] taken_cnt,
  output logic [CNT_W-1:0] untaken_cnt
);
  import lsa_pkg::*;

  localparam int NSRC  = 2;
  localparam int ACC_W = CYC_W;

  logic [ACC_W-1:0] ld_inst, br_inst, grp_ld, grp_br;
  logic [TOT_W-1:0] insn_tot, charge;
  logic [NUM_CNT-1:0]           cnt_en;
  logic [TOT_W-1:0]             cnt_inc [NUM_CNT];
  logic [CNT_W-1:0]             cnt_q   [NUM_CNT];

  assign br_inst = (br_en && br_taken) ? ACC_W'(BR_PEN) : '0;

  lsa_hazard #(.NREG(NREG), .NSRC(NSRC), .ACC_W(ACC_W)) hazard_i (
    .clk     (clk),
    .rst     (rst),
    .valid   (ins_valid),
    .first   (ins_first),
    .src_en  ({rd_b_en, rd_a_en}),
    .src_idx ({rd_b_reg, rd_a_reg}),
    .ld_en   (ld_en),
    .ld_idx  (ld_reg),
    .stall   (ld_inst)
  );

  lsa_pair #(.CYC_W(CYC_W), .ACC_W(ACC_W)) pair_i (
    .clk      (clk),
    .rst      (rst),
    .valid    (ins_valid),
    .first    (ins_first),
    .last     (ins_last),
    .base     (base_cyc),
    .ld_inst  (ld_inst),
    .br_inst  (br_inst),
    .grp_ld   (grp_ld),
    .grp_br   (grp_br),
    .insn_tot (insn_tot),
    .charge   (charge)
  );

  always_comb begin
    cnt_en[CNT_TOTAL]    = ins_valid && ins_last;
    cnt_en[CNT_LDSTALL]  = ins_valid && ins_last;
    cnt_en[CNT_BRSTALL]  = ins_valid && ins_last;
    cnt_en[CNT_TAKEN]    = ins_valid && br_en && br_taken;
    cnt_en[CNT_UNTAKEN]  = ins_valid && br_en && !br_taken;
    cnt_inc[CNT_TOTAL]   = charge;
    cnt_inc[CNT_LDSTALL] = TOT_W'(grp_ld);
    cnt_inc[CNT_BRSTALL] = TOT_W'(grp_br);
    cnt_inc[CNT_TAKEN]   = TOT_W'(1);
    cnt_inc[CNT_UNTAKEN] = TOT_W'(1);
  end

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    lsa_sat_cnt #(.W(CNT_W), .INC_W(TOT_W)) cnt_i (
      .clk (clk),
      .rst (rst),
      .en  (cnt_en[k]),
      .inc (cnt_inc[k]),
      .q   (cnt_q[k])
    );
  end

  assign total_cyc    = cnt_q[CNT_TOTAL];
  assign ld_stall_cyc = cnt_q[CNT_LDSTALL];
  assign br_stall_cyc = cnt_q[CNT_BRSTALL];
  assign taken_cnt    = cnt_q[CNT_TAKEN];
  assign untaken_cnt  = cnt_q[CNT_UNTAKEN];

  always_ff @(posedge clk) begin
    if (rst)            insn_cyc <= '0;
    else if (ins_valid) insn_cyc <= insn_tot;
  end

  // R5: an instruction costs at least its base cycles
  a_r5_insn_floor: assert property (@(posedge clk) disable iff (rst)
    ins_valid |=> (insn_cyc >= TOT_W'($past(base_cyc))));

  // R4: branch counts move only for valid branches
  a_r4_branch_quiet: assert property (@(posedge clk) disable iff (rst)
    !(ins_valid && br_en) |=> ($stable(taken_cnt) && $stable(untaken_cnt)));

  // R4: a taken and an untaken count never move together
  a_r4_branch_excl: assert property (@(posedge clk) disable iff (rst)
    ins_valid |=> !(taken_cnt != $past(taken_cnt) && untaken_cnt != $past(untaken_cnt)));

  // R10: idle cycles leave the instruction total alone
  a_r10_insn_hold: assert property (@(posedge clk) disable iff (rst)
    !ins_valid |=> $stable(insn_cyc));
endmodule

// File: tb/lsa_cycle_acct_tb_top.sv
module lsa_cycle_acct_tb_top;
  localparam int CW   = 12;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ins_valid = 0, ins_first = 0, ins_last = 0;
  logic rd_a_en = 0, rd_b_en = 0, ld_en = 0, br_en = 0, br_taken = 0;
  logic [3:0] rd_a_reg = '0, rd_b_reg = '0, ld_reg = '0;
  logic [7:0] base_cyc = '0;
  logic [9:0] insn_cyc;
  logic [CW-1:0] total_cyc, ld_stall_cyc, br_stall_cyc, taken_cnt, untaken_cnt;

  int checks = 0, errors = 0;
  int e_insn = 0, e_tot = 0, e_ld = 0, e_br = 0, e_tk = 0, e_ut = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lsa_cycle_acct #(.NREG(16), .CYC_W(8), .CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_first(ins_first),
    .ins_last(ins_last), .rd_a_en(rd_a_en), .rd_a_reg(rd_a_reg),
    .rd_b_en(rd_b_en), .rd_b_reg(rd_b_reg), .ld_en(ld_en), .ld_reg(ld_reg),
    .br_en(br_en), .br_taken(br_taken), .base_cyc(base_cyc),
    .insn_cyc(insn_cyc), .total_cyc(total_cyc), .ld_stall_cyc(ld_stall_cyc),
    .br_stall_cyc(br_stall_cyc), .taken_cnt(taken_cnt), .untaken_cnt(untaken_cnt)
  );

  function automatic int sat(input int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "insn_cyc", int'(insn_cyc), e_insn);
    chk(tag, "total_cyc", int'(total_cyc), e_tot);
    chk(tag, "ld_stall_cyc", int'(ld_stall_cyc), e_ld);
    chk(tag, "br_stall_cyc", int'(br_stall_cyc), e_br);
    chk(tag, "taken_cnt", int'(taken_cnt), e_tk);
    chk(tag, "untaken_cnt", int'(untaken_cnt), e_ut);
  endtask

  task automatic park();
    ins_valid = 0; ins_first = 0; ins_last = 0; rd_a_en = 0; rd_b_en = 0;
    ld_en = 0; br_en = 0; br_taken = 0; rd_a_reg = '0; rd_b_reg = '0;
    ld_reg = '0; base_cyc = '0;
  endtask

  task automatic issue(input bit f, input bit l, input bit ae, input int a,
                       input bit be, input int b, input bit le, input int ld,
                       input bit bre, input bit tk, input int base);
    @(negedge clk);
    ins_first = f; ins_last = l; rd_a_en = ae; rd_a_reg = 4'(a);
    rd_b_en = be; rd_b_reg = 4'(b); ld_en = le; ld_reg = 4'(ld);
    br_en = bre; br_taken = tk; base_cyc = 8'(base); ins_valid = 1;
    @(negedge clk);
    park();
  endtask

  task automatic t_reset();
    check_all("R1 reset");
  endtask

  task automatic t_load_use();
    issue(1,1, 0,0, 0,0, 1,3, 0,0, 1);
    e_insn = 1; e_tot += 1; check_all("R2 load r3");
    issue(1,1, 1,3, 0,0, 0,0, 0,0, 1);
    e_insn = 3; e_tot += 3; e_ld += 2; check_all("R2 use r3");
    issue(1,1, 0,0, 0,0, 1,5, 0,0, 2);
    e_insn = 2; e_tot += 2; check_all("R3 load r5");
    issue(1,1, 1,5, 1,5, 0,0, 0,0, 1);
    e_insn = 5; e_tot += 5; e_ld += 4; check_all("R3 double hit");
    issue(1,1, 0,0, 0,0, 1,7, 0,0, 1);
    e_insn = 1; e_tot += 1; check_all("R3 load r7");
    issue(1,1, 0,7, 1,6, 0,0, 0,0, 1);
    e_insn = 1; e_tot += 1; check_all("R3 disabled source");
  endtask

  task automatic t_mask_replace();
    issue(1,1, 0,0, 0,0, 1,2, 0,0, 1);
    e_insn = 1; e_tot += 1;
    issue(1,1, 0,0, 0,0, 0,0, 0,0, 1);
    e_insn = 1; e_tot += 1;
    issue(1,1, 1,2, 0,0, 0,0, 0,0, 1);
    e_insn = 1; e_tot += 1; check_all("R6 mask replaced");
  endtask

  task automatic t_branch();
    issue(1,1, 0,0, 0,0, 0,0, 1,1, 1);
    e_insn = 3; e_tot += 3; e_br += 2; e_tk += 1; check_all("R4 taken");
    issue(1,1, 0,0, 0,0, 0,0, 1,0, 4);
    e_insn = 4; e_tot += 4; e_ut += 1; check_all("R4 untaken");
    issue(1,1, 0,0, 0,0, 0,0, 0,1, 2);
    e_insn = 2; e_tot += 2; check_all("R4 taken flag ignored");
  endtask

  task automatic t_pair();
    issue(1,0, 0,0, 0,0, 0,0, 0,0, 5);
    e_insn = 5; check_all("R7 pair first slot");
    issue(0,1, 0,0, 0,0, 0,0, 1,1, 2);
    e_insn = 4; e_tot += 5; e_br += 2; e_tk += 1; check_all("R7 pair max first");
    issue(1,0, 0,0, 0,0, 0,0, 0,0, 1);
    e_insn = 1;
    issue(0,1, 0,0, 0,0, 0,0, 0,0, 9);
    e_insn = 9; e_tot += 9; check_all("R7 pair max last");
  endtask

  task automatic t_pair_load();
    issue(1,0, 0,0, 0,0, 1,4, 0,0, 1);
    e_insn = 1; check_all("R5 pair load slot");
    issue(0,1, 1,4, 0,0, 0,0, 0,0, 1);
    e_insn = 3; e_tot += 3; e_ld += 2; check_all("R5 in-pair load use");
    issue(1,1, 1,4, 0,0, 0,0, 0,0, 1);
    e_insn = 3; e_tot += 3; e_ld += 2; check_all("R2 pending kept to next group");
  endtask

  task automatic t_pair_accum();
    issue(1,0, 0,0, 0,0, 0,0, 1,1, 1);
    e_insn = 3; e_tk += 1; check_all("R8 branch in first slot");
    issue(0,1, 0,0, 0,0, 0,0, 0,0, 1);
    e_insn = 3; e_tot += 3; e_br += 2; check_all("R8 stall counted once");
  endtask

  task automatic t_idle();
    issue(1,1, 0,0, 0,0, 0,0, 0,0, 1);
    e_insn = 1; e_tot += 1;
    @(negedge clk);
    ins_first = 1; ins_last = 1; ld_en = 1; ld_reg = 4'd9; br_en = 1;
    br_taken = 1; base_cyc = 8'd77; rd_a_en = 1; rd_a_reg = 4'd9;
    repeat (5) @(negedge clk);
    park();
    check_all("R10 idle inputs ignored");
    issue(1,1, 1,9, 0,0, 0,0, 0,0, 2);
    e_insn = 2; e_tot += 2; check_all("R10 mask untouched");
  endtask

  task automatic t_sat();
    for (int i = 0; i < 20; i++) begin
      issue(1,1, 0,0, 0,0, 0,0, 0,0, 255);
      e_tot = sat(e_tot + 255);
    end
    e_insn = 255; check_all("R9 total saturates");
    issue(1,1, 0,0, 0,0, 0,0, 0,0, 10);
    e_insn = 10; check_all("R9 saturated hold");
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    park();
    rst = 1;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    @(negedge clk);
    t_reset();
    t_load_use();
    t_mask_replace();
    t_branch();
    t_pair();
    t_pair_load();
    t_pair_accum();
    t_idle();
    t_sat();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule